// File: doc/BRIEF.md
# Shift-and-Add Sigmoid / Tanh Approximator

This unit evaluates either the logistic sigmoid or the hyperbolic tangent of a signed fixed-point operand in a single combinational pass. It is meant to sit directly after an accumulator in a neural-network datapath, where a per-neuron activation must be produced without a table memory and without a general multiplier. The input is a 16-bit two's complement value with 12 fraction bits, so it covers -8.0 up to just under +8.0. The output is a 16-bit two's complement value with 15 fraction bits. A one-bit select chooses the function: 0 gives sigmoid and 1 gives tanh.

The datapath only ever works on the magnitude of the operand. For tanh, the magnitude is doubled first, so that tanh(x) = 2·σ(2|x|) − 1 can reuse the same sigmoid core. The magnitude is then split as (n + u)·ln2 by a shift-and-add product with the constant 1/ln2. The integer n picks the segment, and every segment is ln2 wide. Segment 0 uses the first-order expansion 0.5 + z/4. Segment 1 uses a straight line between its exact end values, 2/3 and 4/5. In higher segments, e^−z = 2^−n·2^−u is formed as a right shift of (1 − u/2), and the tail 1 − σ ≈ t − t² is built from two barrel shifts. The segment classes are NEAR, MID, FAR and SAT. SAT covers arguments of 8.0 or more, which go straight to the asymptote. The sign is restored at the end, through 1 − σ for sigmoid and through negation for tanh, with rounding to nearest and clamping to the largest positive code.

Top module: `actfn_shift_approx`

## Requirements
- R1: With `fn_sel` = 0, `y_out` read as an unsigned fraction (code/32768) differs from the true sigmoid of `x_in` (code/4096) by at most 0.02, for every input code.
- R2: With `fn_sel` = 1, `y_out` read as a signed fraction (code/32768) differs from the true tanh of `x_in` (code/4096) by at most 0.04, for every input code.
- R3: With `fn_sel` = 0 and a signed input code c in −2800..2800, `y_out` equals exactly 16384 + 2·c, which is 0x4000 at c = 0.
- R4: With `fn_sel` = 1 and a signed input code c in −1400..1400, `y_out` equals exactly 8·c as a 16-bit two's complement code.
- R5: With `fn_sel` = 0, bit 15 of `y_out` is always 0, and the input code 0x8000 (−8.0) gives `y_out` = 0x0000.
- R6: With `fn_sel` = 1, input codes of 16384 (+4.0) and above give 0x7FFF, and input codes of −16384 and below give 0x8000.
- R7: With `fn_sel` = 0, for any code c other than 0x8000, the outputs for c and −c add up to 32768. The only exception is a sum of 32767, which occurs when the output for the non-negative code is 0x7FFF.
- R8: With `fn_sel` = 1, the output for −c is the two's complement negation of the output for c. The only exception is when the output for c is 0x7FFF, in which case the output for −c is 0x8000. A non-negative input never gives a negative output, and a negative input never gives a positive one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | 16 | Operand, signed, 12 fraction bits |
| fn_sel | input | 1 | Function select: 0 sigmoid, 1 tanh |
| y_out | output | 16 | Result, signed, 15 fraction bits |

## Verification
Every input code is applied under both function selects and compared against a real-valued model. This catches error growth inside any single segment, as well as steps at the ln2 boundaries between NEAR, MID and FAR. Random codes are applied in ± pairs, which exposes faults in the sign-restore path: a wrong complement or negation shows up as a broken pair relation even when each value alone is close to the curve. Directed codes at zero, at the edges of the exact linear regions, at ±4.0 and at −8.0 separate the NEAR formula and the saturation decode from the approximated segments.

// File: rtl/actq_pkg.sv
package actq_pkg;

    // Which approximation formula applies to the reduced argument
    typedef enum logic [1:0] {
        SEG_NEAR = 2'd0,
        SEG_MID  = 2'd1,
        SEG_FAR  = 2'd2,
        SEG_SAT  = 2'd3
    } seg_e;

    // Function select encoding seen on the fn_sel port
    typedef enum logic {
        FN_SIGMOID = 1'b0,
        FN_TANH    = 1'b1
    } fn_e;

endpackage

// File: rtl/csm_mul.sv
// Product with a constant, built only from shifted copies of the operand
module csm_mul #(
    parameter int             A_W = 16,
    parameter int             K_W = 17,
    parameter logic [K_W-1:0] K   = '0
) (
    input  logic [A_W-1:0]     a,
    output logic [A_W+K_W-1:0] p
);
    localparam int P_W = A_W + K_W;

    logic [P_W-1:0] part [K_W];

    for (genvar b = 0; b < K_W; b++) begin : g_term
        if (K[b]) begin : g_on
            assign part[b] = P_W'(a) << b;
        end else begin : g_off
            assign part[b] = '0;
        end
    end

    always_comb begin
        p = '0;
        for (int b = 0; b < K_W; b++) begin
            p = p + part[b];
        end
    end
endmodule

// File: rtl/rr_split.sv
// Range reduction: arg = (n + u) * ln2, with segment classification
module rr_split import actq_pkg::*; #(
    parameter int Z_W    = 15,
    parameter int Z_FRAC = 12,
    parameter int FR     = 20,
    parameter int KQ     = 16,
    parameter int NW     = 4
) (
    input  logic [Z_W+1:0] arg,
    output seg_e           seg,
    output logic [Z_W-1:0] z,
    output logic [NW-1:0]  n,
    output logic [FR-1:0]  u
);
    localparam int  KINV_W = KQ + 1;
    localparam int  KINV_I = int'((2.0 ** KQ) * 1.4426950408889634);
    localparam logic [KINV_W-1:0] KINV = KINV_W'(KINV_I);
    localparam int  P_W    = Z_W + KINV_W;
    localparam int  PT     = Z_FRAC + KQ;

    logic [P_W-1:0] prod;
    logic           sat;

    assign z = arg[Z_W-1:0];

    csm_mul #(.A_W(Z_W), .K_W(KINV_W), .K(KINV)) u_inv (
        .a (z),
        .p (prod)
    );

    assign sat = |arg[Z_W+1:Z_W];
    assign n   = NW'(prod >> PT);
    assign u   = FR'(prod >> (PT - FR));

    always_comb begin
        if (sat) begin
            seg = SEG_SAT;
        end else if (n == '0) begin
            seg = SEG_NEAR;
        end else if (n == NW'(1)) begin
            seg = SEG_MID;
        end else begin
            seg = SEG_FAR;
        end
    end
endmodule

// File: rtl/sig_core.sv
// Sigmoid of a non-negative reduced argument, FR fraction bits out
module sig_core import actq_pkg::*; #(
    parameter int Z_W    = 15,
    parameter int Z_FRAC = 12,
    parameter int FR     = 20,
    parameter int KQ     = 16,
    parameter int NW     = 4
) (
    input  seg_e           seg,
    input  logic [Z_W-1:0] z,
    input  logic [NW-1:0]  n,
    input  logic [FR-1:0]  u,
    output logic [FR:0]    sig
);
    localparam int S_W    = FR + 2;
    localparam int K2_W   = KQ - 2;
    localparam int K2_I   = int'((2.0 ** KQ) * 2.0 / 15.0);
    localparam logic [K2_W-1:0] K2 = K2_W'(K2_I);
    localparam int TWO3_I = int'((2.0 ** FR) * 2.0 / 3.0);
    localparam logic [S_W-1:0] ONE  = S_W'(1) << FR;
    localparam logic [S_W-1:0] HALF = S_W'(1) << (FR - 1);
    localparam logic [S_W-1:0] TWO3 = S_W'(TWO3_I);
    localparam int NEAR_SH = FR - Z_FRAC - 2;

    logic [FR+K2_W-1:0] slope_p;
    logic [S_W-1:0]     near_v, mid_v, far_v;
    logic [S_W-1:0]     m_lin, t_lin, q_sq, t_sq, uu;

    csm_mul #(.A_W(FR), .K_W(K2_W), .K(K2)) u_slope (
        .a (u),
        .p (slope_p)
    );

    assign uu = S_W'(u);

    // segment 0: 0.5 + z/4
    assign near_v = HALF + (S_W'(z) << NEAR_SH);

    // segment 1: chord from 2/3 to 4/5
    assign mid_v  = TWO3 + S_W'(slope_p >> KQ);

    // segments 2+: 1 - (t - t^2), t = 2^-n (1 - u/2), t^2 = 2^-2n (1 - 3u/4)
    assign m_lin  = ONE - (uu >> 1);
    assign t_lin  = m_lin >> n;
    assign q_sq   = ONE - uu + (uu >> 2);
    assign t_sq   = q_sq >> {n, 1'b0};
    assign far_v  = ONE - t_lin + t_sq;

    always_comb begin
        unique case (seg)
            SEG_NEAR: sig = near_v[FR:0];
            SEG_MID:  sig = mid_v[FR:0];
            SEG_FAR:  sig = far_v[FR:0];
            SEG_SAT:  sig = ONE[FR:0];
            default:  sig = ONE[FR:0];
        endcase
    end
endmodule

// File: rtl/actfn_shift_approx.sv
module actfn_shift_approx import actq_pkg::*; #(
    parameter int IN_W    = 16,
    parameter int IN_FRAC = 12,
    parameter int OUT_W   = 16,
    parameter int FR      = 20,
    parameter int KQ      = 16
) (
    input  logic [IN_W-1:0]  x_in,
    input  logic             fn_sel,
    output logic [OUT_W-1:0] y_out
);
    localparam int Z_W      = IN_W - 1;
    localparam int NW       = IN_W - IN_FRAC;
    localparam int OUT_FRAC = OUT_W - 1;
    localparam int SHR      = FR - OUT_FRAC;
    localparam int Q_W      = OUT_W + 1;
    localparam int X_W      = FR + 2;
    localparam logic [X_W-1:0] ONE_X = X_W'(1) << FR;
    localparam logic [X_W-1:0] RND   = X_W'(1) << (SHR - 1);
    localparam logic [Q_W-1:0] ONE_Q = Q_W'(1) << OUT_FRAC;
    localparam logic [OUT_W-1:0] MAXP = {1'b0, {(OUT_W-1){1'b1}}};

    logic             neg;
    logic [IN_W-1:0]  mag;
    logic [Z_W+1:0]   arg;
    seg_e             seg_w;
    logic [Z_W-1:0]   z;
    logic [NW-1:0]    n;
    logic [FR-1:0]    u;
    logic [FR:0]      sig;
    logic [X_W-1:0]   sig_x, h_x;
    logic [Q_W-1:0]   q_s, q_t;

    assign neg = x_in[IN_W-1];
    assign mag = neg ? (~x_in + IN_W'(1)) : x_in;
    assign arg = fn_sel ? {mag, 1'b0} : {1'b0, mag};

    rr_split #(.Z_W(Z_W), .Z_FRAC(IN_FRAC), .FR(FR), .KQ(KQ), .NW(NW)) u_rr (
        .arg (arg),
        .seg (seg_w),
        .z   (z),
        .n   (n),
        .u   (u)
    );

    sig_core #(.Z_W(Z_W), .Z_FRAC(IN_FRAC), .FR(FR), .KQ(KQ), .NW(NW)) u_core (
        .seg (seg_w),
        .z   (z),
        .n   (n),
        .u   (u),
        .sig (sig)
    );

    assign sig_x = X_W'(sig);
    assign h_x   = (sig_x << 1) - ONE_X;
    assign q_s   = Q_W'((sig_x + RND) >> SHR);
    assign q_t   = Q_W'((h_x + RND) >> SHR);

    always_comb begin
        unique case (fn_e'(fn_sel))
            FN_SIGMOID: begin
                if (neg) begin
                    y_out = OUT_W'(ONE_Q - q_s);
                end else begin
                    y_out = (q_s >= ONE_Q) ? MAXP : OUT_W'(q_s);
                end
            end
            FN_TANH: begin
                if (neg) begin
                    y_out = OUT_W'(Q_W'(0) - q_t);
                end else begin
                    y_out = (q_t >= ONE_Q) ? MAXP : OUT_W'(q_t);
                end
            end
            default: y_out = '0;
        endcase
    end
endmodule

// File: rtl/actfn_shift_approx_chk.sv
module actfn_shift_approx_chk import actq_pkg::*; #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 16
) (
    input logic [IN_W-1:0]  x_in,
    input logic             fn_sel,
    input logic [OUT_W-1:0] y_out,
    input seg_e             seg
);
    always_comb begin
        int xs;
        int ys;
        xs = int'($signed(x_in));
        ys = int'($signed(y_out));
        // R5
        sig_sign_chk: assert (fn_sel || !y_out[OUT_W-1]);
        // R5
        sig_floor_chk: assert (fn_sel || (x_in != 16'h8000) || (y_out == '0));
        // R3
        sig_near_chk: assert (fn_sel || xs > 2800 || xs < -2800 || ys == 16384 + 2 * xs);
        // R4
        tanh_near_chk: assert (!fn_sel || xs > 1400 || xs < -1400 || ys == 8 * xs);
        // R6
        tanh_sat_chk: assert (!fn_sel || (xs < 16384 && xs > -16384)
                              || (xs >= 16384 && y_out == 16'h7FFF)
                              || (xs <= -16384 && y_out == 16'h8000));
        // R6
        sat_class_chk: assert ((seg == SEG_SAT) == (fn_sel ? (xs >= 16384 || xs <= -16384)
                                                           : (xs == -32768)));
        // R8
        tanh_sign_chk: assert (!fn_sel || (xs >= 0 && ys >= 0) || (xs < 0 && ys <= 0));
    end
endmodule

bind actfn_shift_approx actfn_shift_approx_chk u_chk (
    .x_in   (x_in),
    .fn_sel (fn_sel),
    .y_out  (y_out),
    .seg    (seg_w)
);

// File: tb/actfn_shift_approx_test.sv
module actfn_shift_approx_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] x_in;
    logic        fn_sel;
    logic [15:0] y_out;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    actfn_shift_approx uut (
        .x_in   (x_in),
        .fn_sel (fn_sel),
        .y_out  (y_out)
    );

    task automatic drive(input logic [15:0] x, input logic f);
        @(posedge clk);
        x_in   = x;
        fn_sel = f;
        @(negedge clk);
    endtask

    task automatic expect_eq(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: x=%h fn=%0d got %h expected %h", req, x_in, fn_sel, got, exp);
        end
    endtask

    function automatic real ref_val(input logic [15:0] c, input logic f);
        real xr;
        xr = real'($signed(c)) / 4096.0;
        if (f) return $tanh(xr);
        return 1.0 / (1.0 + $exp(-xr));
    endfunction

    task automatic check_bound(input logic [15:0] c, input logic f, input logic [15:0] got);
        real g, e, d, lim;
        g   = f ? real'($signed(got)) / 32768.0 : real'(got) / 32768.0;
        e   = ref_val(c, f);
        d   = (g > e) ? g - e : e - g;
        lim = f ? 0.04 : 0.02;
        checks++;
        if (d > lim) begin
            errors++;
            $display("FAIL %s: x=%h got %f expected %f (err %f)", f ? "R2" : "R1", c, g, e, d);
        end
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int          seed_v;
        logic [15:0] c16, cn, yp, yn;
        logic        f;
        rst    = 1'b1;
        x_in   = 16'h0000;
        fn_sel = 1'b0;
        repeat (5) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // state after reset with a zero operand: sigmoid(0) (R3)
        expect_eq("R3", y_out, 16'h4000);

        // directed corners
        drive(16'h0000, 1'b1); expect_eq("R4", y_out, 16'h0000);
        drive(16'h8000, 1'b0); expect_eq("R5", y_out, 16'h0000);
        drive(16'h8000, 1'b1); expect_eq("R6", y_out, 16'h8000);
        drive(16'h7FFF, 1'b1); expect_eq("R6", y_out, 16'h7FFF);
        drive(16'd16384, 1'b1); expect_eq("R6", y_out, 16'h7FFF);
        drive(16'hC000, 1'b1); expect_eq("R6", y_out, 16'h8000);
        drive(16'd2800, 1'b0); expect_eq("R3", y_out, 16'd21984);
        drive(16'(-2800), 1'b0); expect_eq("R3", y_out, 16'd10784);
        drive(16'd1400, 1'b1); expect_eq("R4", y_out, 16'd11200);
        drive(16'(-1400), 1'b1); expect_eq("R4", y_out, 16'(-11200));

        // exhaustive sweep of both functions
        for (int c = 0; c < 65536; c++) begin
            for (int fi = 0; fi < 2; fi++) begin
                int xs;
                c16 = 16'(c);
                f   = fi[0];
                xs  = int'($signed(c16));
                drive(c16, f);
                check_bound(c16, f, y_out);
                if (!f) begin
                    if (xs <= 2800 && xs >= -2800) expect_eq("R3", y_out, 16'(16384 + 2 * xs));
                    checks++;
                    if (y_out[15]) begin
                        errors++;
                        $display("FAIL R5: x=%h got %h expected bit15 clear", c16, y_out);
                    end
                end else begin
                    if (xs <= 1400 && xs >= -1400) expect_eq("R4", y_out, 16'(8 * xs));
                    if (xs >= 16384) expect_eq("R6", y_out, 16'h7FFF);
                    if (xs <= -16384) expect_eq("R6", y_out, 16'h8000);
                end
            end
        end

        // random +/- pairs for the symmetry relations (R7, R8)
        seed_v = $urandom(13579);
        for (int i = 0; i < 1500; i++) begin
            c16 = 16'($urandom) & 16'h7FFF;
            f   = 1'($urandom % 2);
            cn  = ~c16 + 16'd1;
            drive(c16, f); yp = y_out;
            drive(cn, f);  yn = y_out;
            checks++;
            if (!f) begin
                int s;
                s = int'(yp) + int'(yn);
                if (!(s == 32768 || (s == 32767 && yp == 16'h7FFF))) begin
                    errors++;
                    $display("FAIL R7: x=%h got sum %0d expected 32768", c16, s);
                end
            end else begin
                if (!(yn == 16'(~yp + 16'd1) || (yp == 16'h7FFF && yn == 16'h8000))) begin
                    errors++;
                    $display("FAIL R8: x=%h got %h expected %h", c16, yn, 16'(~yp + 16'd1));
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule